// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a compact 16-bit processor that walks every instruction through a fixed chain of phases: instruction fetch, decode, address evaluation, operand read, execute and result store. It talks to a single word-addressed memory of 64K sixteen-bit words through one request port. Each access holds its request, address, direction and write data steady until the memory answers with a one-cycle ready pulse.

Internally it keeps eight general registers, a program counter, an instruction register, memory address and memory data holding registers, and a three-bit sign flag set (negative, zero, positive). Its instructions cover:

- arithmetic and logic on registers;
- conditional branches on the sign flags;
- direct loads and stores relative to the program counter, plus address generation;
- base-plus-offset loads and stores;
- pointer-indirect loads and stores, which need two memory reads;
- register jumps and returns;
- subroutine calls;
- service calls that fetch their target from a vector table in low memory.

A service call to vector x25 stops the core with its `halt` output raised.

Top module: `cpu16_core`

## Requirements
- R1: Reset clears every general register to zero, sets the sign flags to "zero" (binary 010), deasserts `halt`, and makes the first instruction read go to address x3000.
- R2: An instruction is read from the address in the program counter, and the program counter then advances by one. Every memory access keeps `mem_req`, `mem_addr` and `mem_we` stable until the cycle in which `mem_rdy` is high.
- R3: Opcodes 0010 (load) and 1110 (address generation) work as follows. The target register is bits 11:9. The target address is the advanced program counter plus bits 8:0, sign-extended. Opcode 0011 stores register bits 11:9 to the same kind of address.
- R4: Opcodes 0110 (load) and 0111 (store) form their address as register bits 8:6 plus bits 5:0, sign-extended. The data register is bits 11:9.
- R5: Opcodes 1010 (load) and 1011 (store) first read a pointer word at the program-counter-relative address (9-bit offset). They then use that pointer word as the address of the real operand.
- R6: Opcode 0001 adds and opcode 0101 bitwise-ANDs. Each takes a destination in bits 11:9 and a first source in bits 8:6. The second operand is the register in bits 2:0 when bit 5 is 0, or the sign-extended bits 4:0 when bit 5 is 1. Opcode 1001 writes the bitwise complement of register bits 8:6 to register bits 11:9.
- R7: Opcode 0000 with mask bits 11:9 (negative, zero, positive) branches to the advanced program counter plus sign-extended bits 8:0 when the mask and the flags share a set bit. A mask of 000 never branches. The flags follow the value written by loads, address generation and the R6 operations. Stores, jumps and service calls leave the flags unchanged.
- R8: Opcode 1100 loads the program counter from register bits 8:6. With register 7 selected, this acts as a return.
- R9: Opcode 0100 saves the advanced program counter in register 7. It then jumps either to the advanced program counter plus sign-extended bits 10:0 when bit 11 is 1, or to register bits 8:6 when bit 11 is 0. A register-7 target uses register 7's value from before the save.
- R10: Opcode 1111 saves the advanced program counter in register 7. It then loads the program counter from the memory word whose address is the zero-extended bits 7:0.
- R11: A service call with vector x25 raises `halt` after it reads its vector entry. `halt` then stays high with no further memory requests until reset.
- R12: Opcodes 1000 and 1101 change no register, no flag and no memory, and execution continues at the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request, held until ready |
| mem_we | output | 1 | High for a write access, low for a read |
| mem_addr | output | 16 | Word address of the access |
| mem_wdata | output | 16 | Data for a write access |
| mem_rdata | input | 16 | Read data, valid while `mem_rdy` is high |
| mem_rdy | input | 1 | One-cycle completion pulse for the pending access |
| halt | output | 1 | Core has stopped on a service call to vector x25 |

## Verification
The critical overlap is a subroutine call whose target register is register 7 itself. In that one cycle the core reads register 7 as the jump target and also writes the return link into register 7. A service call has a similar overlap: it writes register 7 in the same cycle that it forms the vector address. The program provokes both overlaps. It loads a known address into register 7 and calls through it, and it makes a service call from code that later stores register 7. Execution must land on the address loaded beforehand, not on the new link, and the stored words must equal the link values worked out by hand.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    parameter int unsigned WORD_W = 16;
    parameter int unsigned NREG   = 8;
    parameter int unsigned OPC_W  = 4;
    parameter int unsigned CC_W   = 3;

    localparam int unsigned RIDX_W = $clog2(NREG);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [OPC_W-1:0]  opc_t;
    typedef logic [CC_W-1:0]   cc_t;

    localparam opc_t OP_BR   = 4'b0000;
    localparam opc_t OP_ADD  = 4'b0001;
    localparam opc_t OP_LD   = 4'b0010;
    localparam opc_t OP_ST   = 4'b0011;
    localparam opc_t OP_JSR  = 4'b0100;
    localparam opc_t OP_AND  = 4'b0101;
    localparam opc_t OP_LDR  = 4'b0110;
    localparam opc_t OP_STR  = 4'b0111;
    localparam opc_t OP_RSV8 = 4'b1000;
    localparam opc_t OP_NOT  = 4'b1001;
    localparam opc_t OP_LDI  = 4'b1010;
    localparam opc_t OP_STI  = 4'b1011;
    localparam opc_t OP_JMP  = 4'b1100;
    localparam opc_t OP_RSVD = 4'b1101;
    localparam opc_t OP_LEA  = 4'b1110;
    localparam opc_t OP_TRAP = 4'b1111;

    localparam ridx_t LINK_REG = ridx_t'(NREG - 1);
    localparam cc_t   CC_NEG   = 3'b100;
    localparam cc_t   CC_ZERO  = 3'b010;
    localparam cc_t   CC_POS   = 3'b001;
    localparam word_t PC_STEP  = word_t'(1);

    typedef enum logic [3:0] {
        PH_FETCH,
        PH_IFETCH,
        PH_DECODE,
        PH_EVAL,
        PH_OPER,
        PH_EXEC,
        PH_STORE,
        PH_HALT
    } phase_t;

    typedef struct packed {
        phase_t ph;
        word_t  pc;
        word_t  ir;
        word_t  mar;
        word_t  mdr;
        cc_t    cc;
        logic   ind;
    } core_t;

    function automatic word_t sext5(input logic [4:0] v);
        return {{(WORD_W-5){v[4]}}, v};
    endfunction

    function automatic word_t sext6(input logic [5:0] v);
        return {{(WORD_W-6){v[5]}}, v};
    endfunction

    function automatic word_t sext9(input logic [8:0] v);
        return {{(WORD_W-9){v[8]}}, v};
    endfunction

    function automatic word_t sext11(input logic [10:0] v);
        return {{(WORD_W-11){v[10]}}, v};
    endfunction

    function automatic word_t zext8(input logic [7:0] v);
        return {{(WORD_W-8){1'b0}}, v};
    endfunction

    function automatic cc_t cc_of(input word_t v);
        if (v[WORD_W-1])
            return CC_NEG;
        else if (v == '0)
            return CC_ZERO;
        else
            return CC_POS;
    endfunction

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
    import cpu16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t ra_addr,
    output word_t ra_data,
    input  ridx_t rb_addr,
    output word_t rb_data,
    input  logic  wr_en,
    input  ridx_t wr_addr,
    input  word_t wr_data
);

    word_t regs_q [NREG];
    word_t regs_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_addr == ridx_t'(g)))
                regs_d[g] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else
                regs_q[g] <= regs_d[g];
        end
    end

    assign ra_data = regs_q[ra_addr];
    assign rb_data = regs_q[rb_addr];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
(
    input  opc_t       opc,
    input  word_t      src_a,
    input  word_t      src_b,
    input  logic       use_imm,
    input  logic [4:0] imm5,
    output word_t      result
);

    word_t opnd;

    assign opnd = use_imm ? sext5(imm5) : src_b;

    always_comb begin
        case (opc)
            OP_ADD:  result = src_a + opnd;
            OP_AND:  result = src_a & opnd;
            OP_NOT:  result = ~src_a;
            default: result = src_a;
        endcase
    end

endmodule

// File: rtl/cpu16_agen.sv
module cpu16_agen
    import cpu16_pkg::*;
(
    input  word_t ir,
    input  word_t pc,
    input  word_t base,
    output word_t ea
);

    always_comb begin
        case (ir[15:12])
            OP_LDR, OP_STR: ea = base + sext6(ir[5:0]);
            OP_JMP:         ea = base;
            OP_JSR:         ea = ir[11] ? (pc + sext11(ir[10:0])) : base;
            OP_TRAP:        ea = zext8(ir[7:0]);
            default:        ea = pc + sext9(ir[8:0]);
        endcase
    end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = 16'h3000,
    parameter logic [7:0]        HALT_VEC = 8'h25
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              halt
);

    core_t st_q;
    core_t st_d;

    opc_t  opc;
    ridx_t dst;
    ridx_t ra_addr;
    ridx_t rb_addr;
    word_t ra_data;
    word_t rb_data;
    word_t alu_y;
    word_t ea;
    logic  wr_en;
    ridx_t wr_addr;
    word_t wr_data;
    logic  store_src;

    assign opc       = st_q.ir[15:12];
    assign dst       = st_q.ir[11:9];
    assign store_src = (opc == OP_ST) || (opc == OP_STR) || (opc == OP_STI);
    assign ra_addr   = st_q.ir[8:6];
    assign rb_addr   = store_src ? st_q.ir[11:9] : st_q.ir[2:0];

    cpu16_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    cpu16_alu u_alu (
        .opc     (opc),
        .src_a   (ra_data),
        .src_b   (rb_data),
        .use_imm (st_q.ir[5]),
        .imm5    (st_q.ir[4:0]),
        .result  (alu_y)
    );

    cpu16_agen u_agen (
        .ir   (st_q.ir),
        .pc   (st_q.pc),
        .base (ra_data),
        .ea   (ea)
    );

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = dst;
        wr_data = '0;

        case (st_q.ph)
            PH_FETCH: begin
                st_d.mar = st_q.pc;
                st_d.pc  = st_q.pc + PC_STEP;
                st_d.ph  = PH_IFETCH;
            end

            PH_IFETCH: begin
                if (mem_rdy) begin
                    st_d.mdr = mem_rdata;
                    st_d.ph  = PH_DECODE;
                end
            end

            PH_DECODE: begin
                st_d.ir = st_q.mdr;
                st_d.ph = PH_EVAL;
            end

            PH_EVAL: begin
                st_d.ph = PH_FETCH;
                case (opc)
                    OP_ADD, OP_AND, OP_NOT: begin
                        wr_en   = 1'b1;
                        wr_data = alu_y;
                        st_d.cc = cc_of(alu_y);
                    end
                    OP_BR: begin
                        if ((st_q.ir[11:9] & st_q.cc) != '0)
                            st_d.pc = ea;
                    end
                    OP_LEA: begin
                        wr_en   = 1'b1;
                        wr_data = ea;
                        st_d.cc = cc_of(ea);
                    end
                    OP_LD, OP_LDR, OP_LDI, OP_STI: begin
                        st_d.mar = ea;
                        st_d.ph  = PH_OPER;
                    end
                    OP_ST, OP_STR: begin
                        st_d.mar = ea;
                        st_d.mdr = rb_data;
                        st_d.ph  = PH_STORE;
                    end
                    OP_JMP: begin
                        st_d.pc = ea;
                    end
                    OP_JSR: begin
                        wr_en   = 1'b1;
                        wr_addr = LINK_REG;
                        wr_data = st_q.pc;
                        st_d.pc = ea;
                    end
                    OP_TRAP: begin
                        wr_en    = 1'b1;
                        wr_addr  = LINK_REG;
                        wr_data  = st_q.pc;
                        st_d.mar = ea;
                        st_d.ph  = PH_OPER;
                    end
                    OP_RSV8, OP_RSVD: begin
                        st_d.ph = PH_FETCH;
                    end
                    default: begin
                        st_d.ph = PH_FETCH;
                    end
                endcase
            end

            PH_OPER: begin
                if (mem_rdy) begin
                    st_d.mdr = mem_rdata;
                    st_d.ph  = PH_EXEC;
                end
            end

            PH_EXEC: begin
                st_d.ph = PH_FETCH;
                case (opc)
                    OP_LD, OP_LDR: begin
                        wr_en   = 1'b1;
                        wr_data = st_q.mdr;
                        st_d.cc = cc_of(st_q.mdr);
                    end
                    OP_LDI: begin
                        if (!st_q.ind) begin
                            st_d.mar = st_q.mdr;
                            st_d.ind = 1'b1;
                            st_d.ph  = PH_OPER;
                        end else begin
                            wr_en    = 1'b1;
                            wr_data  = st_q.mdr;
                            st_d.cc  = cc_of(st_q.mdr);
                            st_d.ind = 1'b0;
                        end
                    end
                    OP_STI: begin
                        st_d.mar = st_q.mdr;
                        st_d.mdr = rb_data;
                        st_d.ph  = PH_STORE;
                    end
                    OP_TRAP: begin
                        st_d.pc = st_q.mdr;
                        if (st_q.ir[7:0] == HALT_VEC)
                            st_d.ph = PH_HALT;
                    end
                    default: begin
                        st_d.ph = PH_FETCH;
                    end
                endcase
            end

            PH_STORE: begin
                if (mem_rdy)
                    st_d.ph = PH_FETCH;
            end

            PH_HALT: begin
                st_d.ph = PH_HALT;
            end

            default: begin
                st_d.ph = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph  <= PH_FETCH;
            st_q.pc  <= RESET_PC;
            st_q.ir  <= '0;
            st_q.mar <= '0;
            st_q.mdr <= '0;
            st_q.cc  <= CC_ZERO;
            st_q.ind <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req   = (st_q.ph == PH_IFETCH) || (st_q.ph == PH_OPER) || (st_q.ph == PH_STORE);
    assign mem_we    = (st_q.ph == PH_STORE);
    assign mem_addr  = st_q.mar;
    assign mem_wdata = st_q.mdr;
    assign halt      = (st_q.ph == PH_HALT);

endmodule

// File: rtl/cpu16_checker.sv
module cpu16_checker
    import cpu16_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_rdy,
    input logic              halt,
    input logic [WORD_W-1:0] mem_addr
);

    localparam logic [WORD_W-1:0] BOOT_ADDR = 16'h3000;

    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> mem_req);

    a_r2_access_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> ($stable(mem_addr) && $stable(mem_we)));

    a_r1_boot_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (mem_req && !mem_we && (mem_addr == BOOT_ADDR)));

    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_req);

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

endmodule

bind cpu16_core cpu16_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_rdy  (mem_rdy),
    .halt     (halt),
    .mem_addr (mem_addr)
);

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rdy;
    logic        halt;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cpu16_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .halt      (halt)
    );

    // Sparse memory model: pages x00xx, x30xx, x31xx, x32xx map to distinct slots.
    logic [15:0] mem [0:2047];

    function automatic int unsigned midx(input logic [15:0] a);
        return {21'd0, a[13], a[9:8], a[7:0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_rdy   <= 1'b0;
            mem_rdata <= 16'h0;
        end else begin
            mem_rdy <= 1'b0;
            if (mem_req && !mem_rdy) begin
                mem_rdy   <= 1'b1;
                mem_rdata <= mem[midx(mem_addr)];
                if (mem_we)
                    mem[midx(mem_addr)] <= mem_wdata;
            end
        end
    end

    // Main program image: {address, word}
    localparam int PROG_N = 49;
    localparam logic [31:0] PROG [PROG_N] = '{
        32'h3000_2C7F, // LD  R6 <- x3080            (R3)
        32'h3001_227F, // LD  R1 <- x3081 (neg)      (R3, R7)
        32'h3002_7380, // STR R1 -> R6+0             (R4)
        32'h3003_0801, // BRn +1, flags from LD      (R7)
        32'h3004_7381, // skipped store              (R7)
        32'h3005_E5FB, // LEA R2, -5                 (R3)
        32'h3006_7582, // STR R2 -> R6+2
        32'h3007_A67A, // LDI R3 via x3082           (R5)
        32'h3008_7783, // STR R3 -> R6+3
        32'h3009_B279, // STI R1 via x3083           (R5)
        32'h300A_2879, // LD  R4 <- x3084
        32'h300B_6B3D, // LDR R5 <- R4-3             (R4)
        32'h300C_7B3F, // STR R5 -> R4-1             (R4)
        32'h300D_1B7F, // ADD R5, R5, #-1            (R6)
        32'h300E_5141, // AND R0, R5, R1             (R6)
        32'h300F_903F, // NOT R0, R0                 (R6)
        32'h3010_7184, // STR R0 -> R6+4
        32'h3011_D000, // reserved opcode            (R12)
        32'h3012_8000, // reserved opcode            (R12)
        32'h3013_0401, // BRz +1 not taken           (R7)
        32'h3014_7185, // STR R0 -> R6+5
        32'h3015_480A, // JSR +10 -> x3020           (R9)
        32'h3016_E419, // LEA R2 -> x3030
        32'h3017_4080, // JSRR R2                    (R9)
        32'h3018_F030, // TRAP x30                   (R10)
        32'h3019_0001, // BR mask 000, never taken   (R7)
        32'h301A_738A, // STR R1 -> R6+10
        32'h301B_F025, // TRAP x25, halt             (R11)
        32'h3020_7F87, // STR R7 -> R6+7
        32'h3021_C1C0, // RET                        (R8)
        32'h3030_7F88, // STR R7 -> R6+8
        32'h3031_E7E6, // LEA R3 -> x3018
        32'h3032_C0C0, // JMP R3                     (R8)
        32'h3040_7F89, // STR R7 -> R6+9
        32'h3041_EE06, // LEA R7 -> x3048
        32'h3042_41C0, // JSRR R7: target is old R7  (R9)
        32'h3048_7F8B, // STR R7 -> R6+11
        32'h3049_E7CF, // LEA R3 -> x3019
        32'h304A_C0C0, // JMP R3                     (R8)
        32'h3080_3200,
        32'h3081_8005,
        32'h3082_3100,
        32'h3083_3101,
        32'h3084_3105,
        32'h3100_1234,
        32'h3102_00A0,
        32'h3201_BEEF,
        32'h0030_3040,
        32'h0025_3050
    };

    // Expected memory after halt: {requirement, address, value}
    localparam int EXP_N = 13;
    localparam logic [35:0] EXPECT [EXP_N] = '{
        36'h3_3200_8005, // R3 load result stored
        36'h7_3201_BEEF, // R7 taken branch skipped store
        36'h3_3202_3001, // R3 address generation
        36'h5_3203_1234, // R5 indirect load
        36'h5_3101_8005, // R5 indirect store
        36'h4_3104_00A0, // R4 base+offset, negative offsets
        36'h6_3204_FFFA, // R6 ADD/AND/NOT chain
        36'hC_3205_FFFA, // R12 reserved opcodes are no-ops
        36'h9_3207_3016, // R9 JSR link
        36'h9_3208_3018, // R9 JSRR link
        36'hA_3209_3019, // R10 trap link
        36'h9_320B_3043, // R9 JSRR through R7 uses old R7
        36'h8_320A_8005  // R8 jumps returned to main line
    };

    task automatic chk(input bit ok, input int unsigned req,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    endtask

    task automatic boot_and_check();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(halt == 1'b0, 1, {15'd0, halt}, 16'h0);      // R1 halt low in reset
        chk(mem_req == 1'b0, 1, {15'd0, mem_req}, 16'h0); // R1 no access in reset
        rst = 1'b0;
        @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == 16'h3000, 2, mem_addr, 16'h3000); // R2/R1 boot fetch
    endtask

    task automatic wait_halt(input int unsigned limit);
        bit seen = 1'b0;
        for (int i = 0; i < int'(limit); i++) begin
            @(negedge clk);
            if (halt) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen, 11, {15'd0, halt}, 16'h1); // R11 halt reached (watchdog)
    endtask

    initial begin
        // Test A: full program walked from the table
        clear_mem();
        for (int i = 0; i < PROG_N; i++) mem[midx(PROG[i][31:16])] = PROG[i][15:0];
        boot_and_check();
        wait_halt(5000);
        for (int i = 0; i < EXP_N; i++) begin
            chk(mem[midx(EXPECT[i][31:16])] == EXPECT[i][15:0], int'(EXPECT[i][35:32]),
                mem[midx(EXPECT[i][31:16])], EXPECT[i][15:0]);
        end
        begin
            int quiet_viol = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_req || !halt) quiet_viol++;
            end
            chk(quiet_viol == 0, 11, 16'(quiet_viol), 16'h0); // R11 stays halted and quiet
        end

        // Test B: flags reset to zero and registers reset to zero (R1)
        rst = 1'b1;
        @(negedge clk);
        clear_mem();
        mem[midx(16'h3000)] = 16'h0401; // BRz +1 relies on reset flags
        mem[midx(16'h3001)] = 16'hF025; // halt early if branch wrongly not taken
        mem[midx(16'h3002)] = 16'h300D; // ST R0 -> x3010
        mem[midx(16'h3003)] = 16'hF025;
        mem[midx(16'h3010)] = 16'hAAAA;
        mem[midx(16'h0025)] = 16'h3050;
        boot_and_check();
        wait_halt(2000);
        chk(mem[midx(16'h3010)] == 16'h0000, 1, mem[midx(16'h3010)], 16'h0000); // R1

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11: actual=watchdog expected=halt");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule